// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block is a data cache with one 32-bit word per line. It sits between a processor-side request port and a slower memory port. Each byte address is split into three parts. The two lowest bits are a byte offset, which the controller ignores because every access covers a whole word. The next bits pick a line. The remaining upper bits are kept as that line's tag. Each line also stores a valid flag and, in write-back builds, a dirty flag. The default is 1024 lines, which gives 4 KB.

A read hit is answered in the same cycle as the request. A miss keeps `cpu_ready` low while a hardware sequencer fetches the word from memory. In write-back builds, if the victim line is both valid and dirty, the sequencer first writes that line out, then fetches, then answers. The processor must hold its request unchanged until it sees `cpu_ready` high at a clock edge.

The parameter `WRITE_BACK` selects the write policy:
- When it is 1, writes update only the cache and a write miss allocates the line.
- When it is 0, every write goes to memory with its byte enables, a write hit also updates the cached word, and a write miss leaves the cache unchanged.

Top module: `dm_cache_ctrl`

## Requirements
- R1: The address is split as byte offset = bits [1:0] (ignored), line index = bits [11:2], and tag = bits [31:12]. Two addresses that share an index but differ in tag evict each other, and any offset within a cached word hits.
- R2: After reset every line is invalid, and with no request pending `cpu_ready` and `mem_req` are both low.
- R3: A read that hits raises `cpu_ready` in the same cycle as `cpu_req`, returns the cached word on `cpu_rdata`, and starts no memory transfer. `cpu_ready` is never high without `cpu_req`.
- R4: A read miss holds `cpu_ready` low and issues one memory read of the word-aligned request address. One cycle after that read's `mem_ack`, `cpu_ready` rises with the fetched word on `cpu_rdata`, and the line then hits.
- R5: From an empty cache, the read addresses 0, 4, 8188, 0, 16384, 0 give miss, miss, miss, hit, miss, miss.
- R6: In write-back mode, a write hit completes in the same cycle, updates only the cache, and marks the line dirty. No memory transfer happens.
- R7: In write-back mode, a miss whose victim is valid and dirty first writes the victim's whole word (`mem_be` all ones) to the victim's own address, then refills. A clean or invalid victim causes no memory write.
- R8: In write-back mode, a write miss refills the line first, then merges the write data into it, leaving the line valid and dirty.
- R9: Byte-enable bit i selects data bits [8i+7:8i]. Unselected bytes keep their previous value, whether that value comes from a hit or from a fresh refill.
- R10: In write-through mode, every write issues one memory write of `cpu_wdata` with `cpu_be` to the aligned request address. A hit also updates the cache. A miss neither fetches nor allocates, and replacement never writes memory.
- R11: Once `mem_req` is raised, it stays high with a stable address and direction until `mem_ack`. The memory may take any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_ready | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enables |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory transfer done |

## Verification
A hit is due in the cycle of the request, so the bench drives each access on a falling edge and samples `cpu_ready` a quarter period later, before the next rising edge. A hit is therefore recognised when zero cycles have been waited. Any miss is due one cycle after the last memory acknowledge, and memory latency varies by design. For that reason the bench never assumes a fixed cycle count for a miss. Instead it polls at the same quarter-period point each cycle and then checks how many memory reads and writes the access caused, and to which address and with what data.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

   // Miss sequencer states
   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,  // accept requests, answer hits
      S_WRITE = 2'd1,  // memory write: dirty victim or write-through word
      S_FILL  = 2'd2,  // memory read of the missing word
      S_REPLY = 2'd3   // hand the finished access back to the processor
   } dmc_state_e;

endpackage

// File: rtl/dmc_byte_merge.sv
module dmc_byte_merge #(
   parameter int DATA_W = 32,
   localparam int BE_W = DATA_W / 8
) (
   input  logic [DATA_W-1:0] base_i,
   input  logic [DATA_W-1:0] upd_i,
   input  logic [BE_W-1:0]   be_i,
   output logic [DATA_W-1:0] merged_o
);

   for (genvar b = 0; b < BE_W; b++) begin : g_lane
      assign merged_o[8*b +: 8] = be_i[b] ? upd_i[8*b +: 8] : base_i[8*b +: 8];
   end

endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
   parameter int DATA_W     = 32,
   parameter int LINES      = 1024,
   parameter int TAG_W      = 20,
   parameter bit WRITE_BACK = 1'b1,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx_i,
   output logic              valid_o,
   output logic              dirty_o,
   output logic [TAG_W-1:0]  tag_o,
   output logic [DATA_W-1:0] data_o,
   input  logic              wr_en_i,
   input  logic [TAG_W-1:0]  wr_tag_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wr_dirty_i
);

   logic [LINES-1:0]  valid_q;
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en_i) begin
         valid_q[idx_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en_i) begin
         tag_q[idx_i]  <= wr_tag_i;
         data_q[idx_i] <= wr_data_i;
      end
   end

   assign valid_o = valid_q[idx_i];
   assign tag_o   = tag_q[idx_i];
   assign data_o  = data_q[idx_i];

   if (WRITE_BACK) begin : g_dirty
      logic [LINES-1:0] dirty_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dirty_q <= '0;
         end else if (wr_en_i) begin
            dirty_q[idx_i] <= wr_dirty_i;
         end
      end
      assign dirty_o = dirty_q[idx_i];
   end else begin : g_no_dirty
      logic unused_dirty;
      assign unused_dirty = wr_dirty_i;
      assign dirty_o      = 1'b0;
   end

endmodule

// File: rtl/dmc_miss_seq.sv
module dmc_miss_seq
   import dmc_pkg::*;
#(
   parameter bit WRITE_BACK = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_i,
   input  logic       we_i,
   input  logic       hit_i,
   input  logic       victim_dirty_i,
   input  logic       ack_i,
   output dmc_state_e state_o
);

   dmc_state_e state_q, state_d;

   if (WRITE_BACK) begin : g_wb
      always_comb begin
         state_d = state_q;
         unique case (state_q)
            S_IDLE: begin
               if (req_i && !hit_i) begin
                  state_d = victim_dirty_i ? S_WRITE : S_FILL;
               end
            end
            S_WRITE: if (ack_i) state_d = S_FILL;
            S_FILL:  if (ack_i) state_d = S_REPLY;
            S_REPLY: state_d = S_IDLE;
            default: state_d = S_IDLE;
         endcase
      end
   end else begin : g_wt
      logic unused_victim;
      assign unused_victim = victim_dirty_i;
      always_comb begin
         state_d = state_q;
         unique case (state_q)
            S_IDLE: begin
               if (req_i && we_i) begin
                  state_d = S_WRITE;
               end else if (req_i && !hit_i) begin
                  state_d = S_FILL;
               end
            end
            S_WRITE: if (ack_i) state_d = S_REPLY;
            S_FILL:  if (ack_i) state_d = S_REPLY;
            S_REPLY: state_d = S_IDLE;
            default: state_d = S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
   import dmc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINES      = 1024,
   parameter bit WRITE_BACK = 1'b1,
   localparam int BE_W  = DATA_W / 8,
   localparam int OFF_W = $clog2(BE_W),
   localparam int IDX_W = $clog2(LINES),
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [BE_W-1:0]   cpu_be,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [BE_W-1:0]   mem_be,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data_w
      $error("dm_cache_ctrl: DATA_W must be a multiple of 8 and at least 16");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("dm_cache_ctrl: LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("dm_cache_ctrl: address too narrow for the chosen line count");
   end

   // address split
   logic [IDX_W-1:0] req_idx;
   logic [TAG_W-1:0] req_tag;
   logic             unused_off;
   assign req_idx    = cpu_addr[OFF_W +: IDX_W];
   assign req_tag    = cpu_addr[ADDR_W-1 -: TAG_W];
   assign unused_off = ^cpu_addr[OFF_W-1:0];

   // line storage
   logic              line_valid, line_dirty;
   logic [TAG_W-1:0]  line_tag;
   logic [DATA_W-1:0] line_data;
   logic              st_we, st_dirty;
   logic [DATA_W-1:0] st_data;

   dmc_line_store #(
      .DATA_W     (DATA_W),
      .LINES      (LINES),
      .TAG_W      (TAG_W),
      .WRITE_BACK (WRITE_BACK)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx_i      (req_idx),
      .valid_o    (line_valid),
      .dirty_o    (line_dirty),
      .tag_o      (line_tag),
      .data_o     (line_data),
      .wr_en_i    (st_we),
      .wr_tag_i   (req_tag),
      .wr_data_i  (st_data),
      .wr_dirty_i (st_dirty)
   );

   logic hit;
   assign hit = line_valid && (line_tag == req_tag);

   // byte merges: into the cached word, and into the word arriving from memory
   logic [DATA_W-1:0] merged_hit, merged_fill;

   dmc_byte_merge #(.DATA_W(DATA_W)) u_merge_hit (
      .base_i   (line_data),
      .upd_i    (cpu_wdata),
      .be_i     (cpu_be),
      .merged_o (merged_hit)
   );

   dmc_byte_merge #(.DATA_W(DATA_W)) u_merge_fill (
      .base_i   (mem_rdata),
      .upd_i    (cpu_wdata),
      .be_i     (cpu_be),
      .merged_o (merged_fill)
   );

   // sequencer
   dmc_state_e state;

   dmc_miss_seq #(.WRITE_BACK(WRITE_BACK)) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_i          (cpu_req),
      .we_i           (cpu_we),
      .hit_i          (hit),
      .victim_dirty_i (line_valid && line_dirty),
      .ack_i          (mem_ack),
      .state_o        (state)
   );

   logic [ADDR_W-1:0] req_word_addr;
   assign req_word_addr = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

   assign mem_req = (state == S_WRITE) || (state == S_FILL);
   assign mem_we  = (state == S_WRITE);

   if (WRITE_BACK) begin : g_policy_wb
      // write-back with allocate on write miss
      always_comb begin
         st_we    = 1'b0;
         st_dirty = 1'b0;
         st_data  = mem_rdata;
         if (state == S_IDLE && cpu_req && cpu_we && hit) begin
            st_we    = 1'b1;
            st_dirty = 1'b1;
            st_data  = merged_hit;
         end else if (state == S_FILL && mem_ack) begin
            st_we    = 1'b1;
            st_dirty = cpu_we;
            st_data  = cpu_we ? merged_fill : mem_rdata;
         end
      end
      assign cpu_ready = (state == S_REPLY) || (state == S_IDLE && cpu_req && hit);
      assign mem_addr  = (state == S_WRITE) ? {line_tag, req_idx, {OFF_W{1'b0}}}
                                            : req_word_addr;
      assign mem_wdata = line_data;
      assign mem_be    = '1;
   end else begin : g_policy_wt
      // write-through with write-around on write miss
      always_comb begin
         st_we    = 1'b0;
         st_dirty = 1'b0;
         st_data  = mem_rdata;
         if (state == S_WRITE && mem_ack && hit) begin
            st_we   = 1'b1;
            st_data = merged_hit;
         end else if (state == S_FILL && mem_ack) begin
            st_we   = 1'b1;
            st_data = mem_rdata;
         end
      end
      assign cpu_ready = (state == S_REPLY) ||
                         (state == S_IDLE && cpu_req && !cpu_we && hit);
      assign mem_addr  = req_word_addr;
      assign mem_wdata = cpu_wdata;
      assign mem_be    = (state == S_WRITE) ? cpu_be : '1;
   end

   assign cpu_rdata = line_data;

endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINES      = 1024,
   parameter bit WRITE_BACK = 1'b1,
   localparam int BE_W  = DATA_W / 8,
   localparam int OFF_W = $clog2(BE_W),
   localparam int IDX_W = $clog2(LINES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic [BE_W-1:0]   cpu_be,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [BE_W-1:0]   mem_be,
   input logic              mem_ack
);

   AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req); // R3

   AST_MEM_STALLS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready); // R4

   AST_FILL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |->
         (mem_addr == {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}})); // R4

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11

   if (WRITE_BACK) begin : g_wb
      logic unused_wb;
      assign unused_wb = ^{cpu_wdata, cpu_be, mem_wdata};

      AST_VICTIM_SAME_LINE: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_req && mem_we) |->
            (mem_addr[OFF_W +: IDX_W] == cpu_addr[OFF_W +: IDX_W]) && (mem_be == '1)); // R7

      AST_VICTIM_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we)); // R7
   end else begin : g_wt
      AST_THROUGH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_req && mem_we) |->
            (mem_addr == {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}) &&
            (mem_wdata == cpu_wdata) && (mem_be == cpu_be)); // R10

      AST_NO_FILL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_req && !mem_we) |-> !cpu_we); // R10
   end

endmodule

bind dm_cache_ctrl dmc_checker #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .LINES      (LINES),
   .WRITE_BACK (WRITE_BACK)
) u_dmc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_we    (cpu_we),
   .cpu_addr  (cpu_addr),
   .cpu_wdata (cpu_wdata),
   .cpu_be    (cpu_be),
   .cpu_ready (cpu_ready),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_be    (mem_be),
   .mem_ack   (mem_ack)
);

// File: tb/test_dm_cache_ctrl.sv
`timescale 1ns/1ps

package tb_dmc_pkg;
   // background content of memory before any write
   function automatic logic [31:0] pat(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h1357_9BDF;
   endfunction

   typedef struct packed {
      logic        we;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [3:0]  be;
      logic        hit;    // expected hit (no wait)
      logic        chk;    // check read data
      logic [31:0] rd;     // expected read data
      logic [1:0]  nwr;    // expected memory writes caused
   } vec_t;
endpackage

module dmc_mem_model (
   input  logic        clk,
   input  logic        req,
   input  logic        we,
   input  logic [31:0] addr,
   input  logic [31:0] wdata,
   input  logic [3:0]  be,
   output logic        ack,
   output logic [31:0] rdata,
   output int          wr_cnt,
   output int          rd_cnt,
   output logic [31:0] last_waddr,
   output logic [31:0] last_wdata,
   output logic [3:0]  last_be,
   output logic [31:0] last_raddr
);
   import tb_dmc_pkg::*;

   logic [31:0] store [logic [31:0]];
   logic        busy;
   int          busy_cnt;
   int          seed;
   logic [31:0] key, cur;

   initial begin
      ack = 1'b0; rdata = '0; busy = 1'b0; busy_cnt = 0; seed = 0;
      wr_cnt = 0; rd_cnt = 0;
      last_waddr = '0; last_wdata = '0; last_be = '0; last_raddr = '0;
   end

   always @(posedge clk) begin
      if (ack) begin
         ack <= 1'b0;
      end else if (req && !busy) begin
         busy     <= 1'b1;
         busy_cnt <= 1 + (seed % 3);
         seed     <= seed + 1;
      end else if (busy) begin
         if (busy_cnt > 1) begin
            busy_cnt <= busy_cnt - 1;
         end else begin
            busy <= 1'b0;
            ack  <= 1'b1;
            key  = {addr[31:2], 2'b00};
            cur  = store.exists(key) ? store[key] : pat(key);
            if (we) begin
               for (int b = 0; b < 4; b++) if (be[b]) cur[8*b +: 8] = wdata[8*b +: 8];
               store[key] = cur;
               wr_cnt     = wr_cnt + 1;
               last_waddr = key;
               last_wdata = wdata;
               last_be    = be;
            end else begin
               rdata      <= cur;
               rd_cnt     = rd_cnt + 1;
               last_raddr = key;
            end
         end
      end
   end
endmodule

module test_dm_cache_ctrl;
   import tb_dmc_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   int n_tests = 0;
   int n_fail  = 0;

   // write-back instance signals
   logic        a_req = 0, a_we = 0;
   logic [31:0] a_addr = '0, a_wdata = '0;
   logic [3:0]  a_be = '0;
   logic        a_rdy, a_mreq, a_mwe, a_mack;
   logic [31:0] a_rdata, a_maddr, a_mwdata, a_mrdata;
   logic [3:0]  a_mbe;
   int          a_wr, a_rd;
   logic [31:0] a_lwa, a_lwd, a_lra;
   logic [3:0]  a_lbe;

   // write-through instance signals
   logic        b_req = 0, b_we = 0;
   logic [31:0] b_addr = '0, b_wdata = '0;
   logic [3:0]  b_be = '0;
   logic        b_rdy, b_mreq, b_mwe, b_mack;
   logic [31:0] b_rdata, b_maddr, b_mwdata, b_mrdata;
   logic [3:0]  b_mbe;
   int          b_wr, b_rd;
   logic [31:0] b_lwa, b_lwd, b_lra;
   logic [3:0]  b_lbe;

   dm_cache_ctrl #(.WRITE_BACK(1'b1)) i_dm_cache_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(a_req), .cpu_we(a_we), .cpu_addr(a_addr), .cpu_wdata(a_wdata),
      .cpu_be(a_be), .cpu_ready(a_rdy), .cpu_rdata(a_rdata),
      .mem_req(a_mreq), .mem_we(a_mwe), .mem_addr(a_maddr), .mem_wdata(a_mwdata),
      .mem_be(a_mbe), .mem_rdata(a_mrdata), .mem_ack(a_mack)
   );

   dmc_mem_model u_mem_a (
      .clk(clk), .req(a_mreq), .we(a_mwe), .addr(a_maddr), .wdata(a_mwdata),
      .be(a_mbe), .ack(a_mack), .rdata(a_mrdata), .wr_cnt(a_wr), .rd_cnt(a_rd),
      .last_waddr(a_lwa), .last_wdata(a_lwd), .last_be(a_lbe), .last_raddr(a_lra)
   );

   dm_cache_ctrl #(.WRITE_BACK(1'b0)) i_dm_cache_ctrl_wt (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(b_req), .cpu_we(b_we), .cpu_addr(b_addr), .cpu_wdata(b_wdata),
      .cpu_be(b_be), .cpu_ready(b_rdy), .cpu_rdata(b_rdata),
      .mem_req(b_mreq), .mem_we(b_mwe), .mem_addr(b_maddr), .mem_wdata(b_mwdata),
      .mem_be(b_mbe), .mem_rdata(b_mrdata), .mem_ack(b_mack)
   );

   dmc_mem_model u_mem_b (
      .clk(clk), .req(b_mreq), .we(b_mwe), .addr(b_maddr), .wdata(b_mwdata),
      .be(b_mbe), .ack(b_mack), .rdata(b_mrdata), .wr_cnt(b_wr), .rd_cnt(b_rd),
      .last_waddr(b_lwa), .last_wdata(b_lwd), .last_be(b_lbe), .last_raddr(b_lra)
   );

   localparam vec_t VECS [12] = '{
      '{1'b0, 32'd0,     32'h0, 4'h0, 1'b0, 1'b1, pat(32'd0),     2'd0},
      '{1'b0, 32'd4,     32'h0, 4'h0, 1'b0, 1'b1, pat(32'd4),     2'd0},
      '{1'b0, 32'd8188,  32'h0, 4'h0, 1'b0, 1'b1, pat(32'd8188),  2'd0},
      '{1'b0, 32'd0,     32'h0, 4'h0, 1'b1, 1'b1, pat(32'd0),     2'd0},
      '{1'b0, 32'd16384, 32'h0, 4'h0, 1'b0, 1'b1, pat(32'd16384), 2'd0},
      '{1'b0, 32'd0,     32'h0, 4'h0, 1'b0, 1'b1, pat(32'd0),     2'd0},
      '{1'b1, 32'd4, 32'hA5A5_A5A5, 4'hF, 1'b1, 1'b0, 32'h0,        2'd0},
      '{1'b0, 32'd4,     32'h0, 4'h0, 1'b1, 1'b1, 32'hA5A5_A5A5,  2'd0},
      '{1'b1, 32'd8, 32'h0000_BEEF, 4'h3, 1'b0, 1'b0, 32'h0,        2'd0},
      '{1'b0, 32'd8,     32'h0, 4'h0, 1'b1, 1'b1,
        (pat(32'd8) & 32'hFFFF_0000) | 32'h0000_BEEF,                2'd0},
      '{1'b0, 32'd4100,  32'h0, 4'h0, 1'b0, 1'b1, pat(32'd4100),  2'd1},
      '{1'b0, 32'd4,     32'h0, 4'h0, 1'b0, 1'b1, 32'hA5A5_A5A5,  2'd0}
   };

   bit timed_out = 1'b0;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", rq, act, exp);
      end
   endtask

   // one processor access; returns wait cycles, read data, memory ops caused
   task automatic acc(input bit wt, input bit we, input logic [31:0] addr,
                      input logic [31:0] wdata, input logic [3:0] be,
                      output int waits, output logic [31:0] rd,
                      output int dwr, output int drd);
      int wr0, rd0;
      bit rdy;
      @(negedge clk);
      wr0 = wt ? b_wr : a_wr;
      rd0 = wt ? b_rd : a_rd;
      if (wt) begin b_req = 1; b_we = we; b_addr = addr; b_wdata = wdata; b_be = be; end
      else    begin a_req = 1; a_we = we; a_addr = addr; a_wdata = wdata; a_be = be; end
      waits = 0;
      #2;
      rdy = wt ? b_rdy : a_rdy;
      while (!rdy && waits < 500) begin
         @(negedge clk);
         #2;
         waits++;
         rdy = wt ? b_rdy : a_rdy;
      end
      rd = wt ? b_rdata : a_rdata;
      @(negedge clk);
      if (wt) b_req = 0; else a_req = 0;
      dwr = (wt ? b_wr : a_wr) - wr0;
      drd = (wt ? b_rd : a_rd) - rd0;
   endtask

   initial begin
      #(8 * 150000);
      timed_out = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %08h expected %08h", 32'd1, 32'd0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int w, dw, dr;
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      // R2: reset state
      chk(!a_rdy && !a_mreq, "R2 reset wb ready/mem_req", {a_rdy, a_mreq}, 0);
      chk(!b_rdy && !b_mreq, "R2 reset wt ready/mem_req", {b_rdy, b_mreq}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!a_rdy && !a_mreq, "R2 idle after reset", {a_rdy, a_mreq}, 0);

      // vector table: R5 sequence then write-back behaviour
      for (int i = 0; i < 12; i++) begin
         acc(1'b0, VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].be, w, rd, dw, dr);
         chk((w == 0) == VECS[i].hit, VECS[i].hit ? "R5/R3 hit expected" : "R5/R4 miss expected",
             w, VECS[i].hit ? 0 : 1);
         if (VECS[i].chk)
            chk(rd == VECS[i].rd, "R4/R9 read data", rd, VECS[i].rd);
         chk(dw == int'(VECS[i].nwr), VECS[i].we ? "R6 write memory traffic" : "R7 victim writes",
             dw, VECS[i].nwr);
         if (!VECS[i].we)
            chk(dr == (VECS[i].hit ? 0 : 1), VECS[i].hit ? "R3 no fetch on hit" : "R4 one fetch",
                dr, VECS[i].hit ? 0 : 1);
         if (i == 8) chk(dr == 1, "R8 write miss allocates", dr, 1);
         if (i == 10) begin
            chk(a_lwa == 32'd4, "R7 victim address", a_lwa, 4);
            chk(a_lwd == 32'hA5A5_A5A5 && a_lbe == 4'hF, "R7 victim data", a_lwd, 32'hA5A5_A5A5);
            chk(a_lra == 32'd4100, "R4 refill address", a_lra, 4100);
         end
      end

      // R1: offset bits ignored, same word hits
      acc(1'b0, 1'b0, 32'd7, 0, 0, w, rd, dw, dr);
      chk(w == 0 && rd == 32'hA5A5_A5A5, "R1 offset within word hits", rd, 32'hA5A5_A5A5);

      // R2: reset invalidates all lines
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      acc(1'b0, 1'b0, 32'd4, 0, 0, w, rd, dw, dr);
      chk(w != 0 && dr == 1, "R2 line invalid after reset", w, 1);
      chk(rd == 32'hA5A5_A5A5, "R2 data refetched after reset", rd, 32'hA5A5_A5A5);

      // R10: write-through instance, write miss goes around
      acc(1'b1, 1'b1, 32'd0, 32'h1122_3344, 4'hF, w, rd, dw, dr);
      chk(w != 0 && dw == 1 && dr == 0, "R10 write-through miss, no fetch", {dw[15:0], dr[15:0]},
          32'h0001_0000);
      chk(b_lwa == 0 && b_lwd == 32'h1122_3344 && b_lbe == 4'hF, "R10 through data", b_lwd,
          32'h1122_3344);
      acc(1'b1, 1'b0, 32'd0, 0, 0, w, rd, dw, dr);
      chk(w != 0 && rd == 32'h1122_3344, "R10 no allocate on write miss", rd, 32'h1122_3344);
      acc(1'b1, 1'b0, 32'd0, 0, 0, w, rd, dw, dr);
      chk(w == 0 && dr == 0, "R3 wt read hit", w, 0);
      acc(1'b1, 1'b1, 32'd0, 32'hAA00_0000, 4'h8, w, rd, dw, dr);
      chk(dw == 1 && b_lbe == 4'h8, "R10 hit writes memory with byte enables", b_lbe, 4'h8);
      acc(1'b1, 1'b0, 32'd0, 0, 0, w, rd, dw, dr);
      chk(w == 0 && rd == 32'hAA22_3344, "R9 byte merge on hit", rd, 32'hAA22_3344);
      acc(1'b1, 1'b0, 32'd16384, 0, 0, w, rd, dw, dr);
      chk(w != 0 && dw == 0 && rd == pat(32'd16384), "R10 replacement without write", dw, 0);

      // R11: a run of misses under varying latency all complete
      for (int k = 0; k < 4; k++) begin
         acc(1'b0, 1'b0, 32'h0002_0000 + 32'(k * 4096), 0, 0, w, rd, dw, dr);
         chk(w > 0 && rd == pat(32'h0002_0000 + 32'(k * 4096)), "R11 variable latency miss", rd,
             pat(32'h0002_0000 + 32'(k * 4096)));
      end

      if (!timed_out) begin
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule